// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-line interrupt controller. Software talks to it through two addresses. It steps through the initialization word sequence, keeps the mask and mode registers, and turns operation command writes into one-cycle strobes that a separate priority resolver acts on. These strobes cover the end-of-interrupt variants and the setting of the rotation offset. It does not resolve priority itself. The resolver hands it the request register, the in-service register and the current poll winner, and the block returns these on reads.

The initialization sequence starts with a control write that has bit 4 set. The next words arrive on address 1. A word carrying the vector base always comes next. A cascade word follows only when single mode is off. A mode word follows only when the first word asked for it. Outside initialization, address-1 writes load the interrupt mask. Address-0 writes with bit 4 clear are command words, split by bit 3.

A separate trigger-mode register sits behind its own select line. It keeps only the bits that a per-instance writable mask allows. All outputs and read data are registered, so every effect is visible on the clock edge that samples the access.

Top module: `irqc_regif`

## Requirements
- R1: A write with tm_sel=0, addr=0 and wdata[4]=1 starts initialization. On that edge init_busy goes to 1 and the mask is cleared. Single mode takes wdata[1] and the mode-word-needed flag takes wdata[0]. Nested and auto-EOI modes, rotate-on-auto-EOI, special mask, read select (back to IRR) and any pending poll are all cleared. init_clear pulses high for one cycle.
- R2: When the starting write also has wdata[3]=1 (level-sensitive mode, unsupported), level_err pulses high for one cycle. The sequence still proceeds.
- R3: The first address-1 write after the start sets base to wdata with bits 2:0 forced to zero. The sequence then ends if single mode is set and no mode word is needed. It waits for the mode word if single mode is set and one is needed. It waits for a cascade word if single mode is clear.
- R4: The cascade word, an address-1 write, changes no register. After it the sequence waits for the mode word if one is needed, otherwise it ends.
- R5: The mode word, an address-1 write, sets nested mode from wdata[4] and auto-EOI from wdata[1], and ends the sequence (init_busy=0).
- R6: An address-1 write with no sequence running loads the mask. Address-1 writes during the sequence leave the mask unchanged.
- R7: A write to addr=0 with wdata[4]=0 and wdata[3]=1 is a read/mode command. If wdata[1]=1, the read select takes wdata[0] (1=ISR, 0=IRR). If wdata[6]=1, special mask takes wdata[5]. A setting whose enable bit is 0 is left as it was.
- R8: The read/mode command with wdata[2]=1 sets a poll request. The next addr=0 read returns 8'h80 OR the poll line when poll_hit=1, and 8'h00 otherwise, and it clears the request.
- R9: A write to addr=0 with wdata[4:3]=00 is an action command with code wdata[7:5]. Code 0 clears rotate-on-auto-EOI and code 4 sets it. Code 2 does nothing.
- R10: Code 1 pulses eoi for one cycle. Code 5 pulses eoi together with eoi_rot.
- R11: Code 3 pulses eoi_spec for one cycle with eoi_line=wdata[2:0]. Code 7 does the same and also pulses eoi_rot.
- R12: Code 6 pulses prio_set for one cycle with prio_base=(wdata[2:0]+1) mod 8. At most one of eoi, eoi_spec and prio_set is high in any cycle.
- R13: A read returns data on rdata one clock after the edge that samples it. Address 1 returns the mask. Address 0 returns ISR or IRR according to the read select, unless a poll is pending.
- R14: A write with tm_sel=1 stores wdata AND TRIG_WMASK in the trigger-mode register, and a read with tm_sel=1 returns it. Such writes touch no other register, and the register holds when it is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_sel | input | 1 | Selects the trigger-mode register instead of the two addresses |
| addr | input | 1 | Register address, 0 or 1 |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| irr_i | input | 8 | Request register from the resolver |
| isr_i | input | 8 | In-service register from the resolver |
| poll_hit_i | input | 1 | Resolver has a winning request |
| poll_line_i | input | 3 | Winning line number |
| rdata | output | 8 | Registered read data |
| imr_o | output | 8 | Interrupt mask |
| base_o | output | 8 | Vector base, low three bits zero |
| single_o | output | 1 | Single mode (no cascade) |
| init_busy_o | output | 1 | Initialization sequence running |
| sfnm_o | output | 1 | Special fully nested mode |
| aeoi_o | output | 1 | Auto-EOI mode |
| rot_aeoi_o | output | 1 | Rotate on auto-EOI |
| smask_o | output | 1 | Special mask mode |
| trig_mode_o | output | 8 | Trigger-mode register |
| init_clear_o | output | 1 | One-cycle pulse telling the resolver to clear its state |
| level_err_o | output | 1 | One-cycle pulse: unsupported level mode requested |
| eoi_o | output | 1 | Non-specific EOI pulse |
| eoi_spec_o | output | 1 | Specific EOI pulse |
| eoi_rot_o | output | 1 | Rotate with the accompanying EOI |
| eoi_line_o | output | 3 | Line of the specific EOI |
| prio_set_o | output | 1 | Set-rotation-offset pulse |
| prio_base_o | output | 3 | New rotation offset |

## Verification
The bench walks every path through the initialization sequence. A design that ignored single mode or the mode-word flag would lose a later mask write into a missing or extra sequence step. The bench checks that the poll byte appears only once. A design that kept the request would return the poll byte on the following read instead of ISR or IRR. The bench also covers the enable bits of the read/mode command, since a decoder that ignored them would change the read select or special mask on unrelated commands. It covers the wrap of the rotation offset from line 7 to 0, and the masking of trigger-mode writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } icw_state_e;

  typedef enum logic [2:0] {
    CMD_ROT_CLR = 3'd0,
    CMD_EOI     = 3'd1,
    CMD_NOP     = 3'd2,
    CMD_SEOI    = 3'd3,
    CMD_ROT_SET = 3'd4,
    CMD_REOI    = 3'd5,
    CMD_SETPRI  = 3'd6,
    CMD_RSEOI   = 3'd7
  } act_cmd_e;

  localparam int BIT_INIT  = 4;
  localparam int BIT_RDCMD = 3;
  localparam int BIT_LEVEL = 3;
endpackage

// File: rtl/irqc_icw_seq.sv
module irqc_icw_seq
  import irqc_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          dat_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic [DW-1:0] imr_o,
  output logic [DW-1:0] base_o,
  output logic          single_o,
  output logic          sfnm_o,
  output logic          aeoi_o,
  output logic          clear_o,
  output logic          level_err_o
);
  localparam logic [DW-1:0] BASE_MASK = {{(DW-LW){1'b1}}, {LW{1'b0}}};

  icw_state_e state_q;
  logic       need4_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      need4_q     <= 1'b0;
      imr_o       <= '0;
      base_o      <= '0;
      single_o    <= 1'b0;
      sfnm_o      <= 1'b0;
      aeoi_o      <= 1'b0;
      clear_o     <= 1'b0;
      level_err_o <= 1'b0;
    end else begin
      clear_o     <= start_i;
      level_err_o <= start_i & wdata_i[BIT_LEVEL];
      if (start_i) begin
        state_q  <= ST_BASE;
        need4_q  <= wdata_i[0];
        single_o <= wdata_i[1];
        imr_o    <= '0;
        sfnm_o   <= 1'b0;
        aeoi_o   <= 1'b0;
      end else if (dat_wr_i) begin
        unique case (state_q)
          ST_IDLE: imr_o <= wdata_i;
          ST_BASE: begin
            base_o <= wdata_i & BASE_MASK;
            if (single_o) state_q <= need4_q ? ST_MODE : ST_IDLE;
            else          state_q <= ST_CASC;
          end
          ST_CASC: state_q <= need4_q ? ST_MODE : ST_IDLE;
          ST_MODE: begin
            sfnm_o  <= wdata_i[4];
            aeoi_o  <= wdata_i[1];
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // R1
  icw1_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (state_q == ST_BASE) && (imr_o == '0) && clear_o);

  // R5
  mode_word_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr_i && !start_i && state_q == ST_MODE) |=>
      (state_q == ST_IDLE) && (sfnm_o == $past(wdata_i[4])));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr_i && !start_i && state_q != ST_IDLE) |=> $stable(imr_o));
endmodule

// File: rtl/irqc_cmd_dec.sv
module irqc_cmd_dec
  import irqc_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr_i,
  input  logic          clear_i,
  input  logic          poll_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rot_aeoi_o,
  output logic          smask_o,
  output logic          rsel_isr_o,
  output logic          poll_o,
  output logic          eoi_o,
  output logic          eoi_spec_o,
  output logic          eoi_rot_o,
  output logic [LW-1:0] eoi_line_o,
  output logic          prio_set_o,
  output logic [LW-1:0] prio_base_o
);
  act_cmd_e        cmd;
  logic            is_rdcmd;
  logic [LW-1:0]   line;

  assign cmd      = act_cmd_e'(wdata_i[DW-1:DW-3]);
  assign is_rdcmd = wdata_i[BIT_RDCMD];
  assign line     = wdata_i[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_aeoi_o  <= 1'b0;
      smask_o     <= 1'b0;
      rsel_isr_o  <= 1'b0;
      poll_o      <= 1'b0;
      eoi_o       <= 1'b0;
      eoi_spec_o  <= 1'b0;
      eoi_rot_o   <= 1'b0;
      eoi_line_o  <= '0;
      prio_set_o  <= 1'b0;
      prio_base_o <= '0;
    end else begin
      eoi_o      <= 1'b0;
      eoi_spec_o <= 1'b0;
      eoi_rot_o  <= 1'b0;
      prio_set_o <= 1'b0;
      if (poll_rd_i) poll_o <= 1'b0;
      if (clear_i) begin
        rot_aeoi_o <= 1'b0;
        smask_o    <= 1'b0;
        rsel_isr_o <= 1'b0;
        poll_o     <= 1'b0;
      end else if (cmd_wr_i && is_rdcmd) begin
        if (wdata_i[2]) poll_o     <= 1'b1;
        if (wdata_i[1]) rsel_isr_o <= wdata_i[0];
        if (wdata_i[6]) smask_o    <= wdata_i[5];
      end else if (cmd_wr_i) begin
        unique case (cmd)
          CMD_ROT_CLR, CMD_ROT_SET: rot_aeoi_o <= cmd[2];
          CMD_EOI, CMD_REOI: begin
            eoi_o     <= 1'b1;
            eoi_rot_o <= cmd[2];
          end
          CMD_SEOI, CMD_RSEOI: begin
            eoi_spec_o <= 1'b1;
            eoi_rot_o  <= cmd[2];
            eoi_line_o <= line;
          end
          CMD_SETPRI: begin
            prio_set_o  <= 1'b1;
            prio_base_o <= line + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eoi_o, eoi_spec_o, prio_set_o}));

  // R10
  rot_pair_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_rot_o |-> (eoi_o || eoi_spec_o));

  // R8
  poll_once_chk: assert property (@(posedge clk) disable iff (rst)
    (poll_rd_i && !cmd_wr_i) |=> !poll_o);

  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_o && !cmd_wr_i) |=> !eoi_o);
endmodule

// File: rtl/irqc_trig_reg.sv
module irqc_trig_reg #(
  parameter int            DW    = 8,
  parameter logic [DW-1:0] WMASK = 8'hF8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] val_o
);
  always_ff @(posedge clk) begin
    if (rst)       val_o <= '0;
    else if (wr_i) val_o <= wdata_i & WMASK;
  end

  // R14
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(val_o));

  // R14
  trig_bits_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> ((val_o & ~WMASK) == '0));
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif #(
  parameter int           LINES      = 8,
  parameter int           LW         = $clog2(LINES),
  parameter int           DW         = 8,
  parameter logic [7:0]   TRIG_WMASK = 8'hF8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tm_sel,
  input  logic          addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  input  logic          poll_hit_i,
  input  logic [LW-1:0] poll_line_i,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] imr_o,
  output logic [DW-1:0] base_o,
  output logic          single_o,
  output logic          init_busy_o,
  output logic          sfnm_o,
  output logic          aeoi_o,
  output logic          rot_aeoi_o,
  output logic          smask_o,
  output logic [DW-1:0] trig_mode_o,
  output logic          init_clear_o,
  output logic          level_err_o,
  output logic          eoi_o,
  output logic          eoi_spec_o,
  output logic          eoi_rot_o,
  output logic [LW-1:0] eoi_line_o,
  output logic          prio_set_o,
  output logic [LW-1:0] prio_base_o
);
  localparam logic [DW-1:0] POLL_FLAG = {1'b1, {(DW-1){1'b0}}};

  logic ctl_wr, start_wr, cmd_wr, dat_wr, trig_wr, poll_rd;
  logic rsel_isr, poll_pend;

  assign ctl_wr   = wr & ~tm_sel & ~addr;
  assign start_wr = ctl_wr & wdata[irqc_pkg::BIT_INIT];
  assign cmd_wr   = ctl_wr & ~wdata[irqc_pkg::BIT_INIT];
  assign dat_wr   = wr & ~tm_sel & addr;
  assign trig_wr  = wr & tm_sel;
  assign poll_rd  = rd & ~tm_sel & ~addr;

  irqc_icw_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_wr), .dat_wr_i(dat_wr),
    .wdata_i(wdata), .busy_o(init_busy_o), .imr_o(imr_o), .base_o(base_o),
    .single_o(single_o), .sfnm_o(sfnm_o), .aeoi_o(aeoi_o),
    .clear_o(init_clear_o), .level_err_o(level_err_o)
  );

  irqc_cmd_dec #(.DW(DW), .LW(LW)) u_dec (
    .clk(clk), .rst(rst), .cmd_wr_i(cmd_wr), .clear_i(start_wr),
    .poll_rd_i(poll_rd), .wdata_i(wdata), .rot_aeoi_o(rot_aeoi_o),
    .smask_o(smask_o), .rsel_isr_o(rsel_isr), .poll_o(poll_pend),
    .eoi_o(eoi_o), .eoi_spec_o(eoi_spec_o), .eoi_rot_o(eoi_rot_o),
    .eoi_line_o(eoi_line_o), .prio_set_o(prio_set_o),
    .prio_base_o(prio_base_o)
  );

  irqc_trig_reg #(.DW(DW), .WMASK(TRIG_WMASK)) u_trig (
    .clk(clk), .rst(rst), .wr_i(trig_wr), .wdata_i(wdata), .val_o(trig_mode_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (tm_sel)         rdata <= trig_mode_o;
      else if (addr)      rdata <= imr_o;
      else if (poll_pend) rdata <= poll_hit_i ? (POLL_FLAG | DW'(poll_line_i)) : '0;
      else                rdata <= rsel_isr ? isr_i : irr_i;
    end
  end

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: tb/irqc_regif_test.sv
module irqc_regif_test;
  localparam logic [7:0] TMASK = 8'hF8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tm_sel = 0, addr = 0, wr = 0, rd = 0;
  logic [7:0] wdata = 0, irr_i = 0, isr_i = 0;
  logic poll_hit_i = 0;
  logic [2:0] poll_line_i = 0;
  logic [7:0] rdata, imr_o, base_o, trig_mode_o;
  logic single_o, init_busy_o, sfnm_o, aeoi_o, rot_aeoi_o, smask_o;
  logic init_clear_o, level_err_o, eoi_o, eoi_spec_o, eoi_rot_o, prio_set_o;
  logic [2:0] eoi_line_o, prio_base_o;

  always #2 clk = ~clk;

  irqc_regif #(.TRIG_WMASK(TMASK)) uut (
    .clk(clk), .rst(rst), .tm_sel(tm_sel), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .irr_i(irr_i), .isr_i(isr_i), .poll_hit_i(poll_hit_i),
    .poll_line_i(poll_line_i), .rdata(rdata), .imr_o(imr_o), .base_o(base_o),
    .single_o(single_o), .init_busy_o(init_busy_o), .sfnm_o(sfnm_o),
    .aeoi_o(aeoi_o), .rot_aeoi_o(rot_aeoi_o), .smask_o(smask_o),
    .trig_mode_o(trig_mode_o), .init_clear_o(init_clear_o),
    .level_err_o(level_err_o), .eoi_o(eoi_o), .eoi_spec_o(eoi_spec_o),
    .eoi_rot_o(eoi_rot_o), .eoi_line_o(eoi_line_o), .prio_set_o(prio_set_o),
    .prio_base_o(prio_base_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  int m_state;
  bit m_need4, m_single, m_sfnm, m_aeoi, m_rot, m_smm, m_rsel, m_poll;
  logic [7:0] m_imr, m_base, m_trig, m_rdata;
  bit e_clr, e_lerr, e_eoi, e_spec, e_erot, e_pset;
  logic [2:0] e_line, e_pbase;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] poll_byte(bit hit, logic [2:0] ln);
    return hit ? (8'h80 | {5'b0, ln}) : 8'h00;
  endfunction

  task automatic clr_pulses();
    e_clr = 0; e_lerr = 0; e_eoi = 0; e_spec = 0; e_erot = 0; e_pset = 0;
  endtask

  task automatic mdl_write(bit sel, bit a, logic [7:0] d);
    clr_pulses();
    if (sel) m_trig = d & TMASK;
    else if (!a && d[4]) begin
      m_state = 1; m_need4 = d[0]; m_single = d[1]; m_imr = 0;
      m_sfnm = 0; m_aeoi = 0; m_rot = 0; m_smm = 0; m_rsel = 0; m_poll = 0;
      e_clr = 1; e_lerr = d[3];
    end else if (!a && d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smm = d[5];
    end else if (!a) begin
      case (d[7:5])
        3'd0: m_rot = 0;
        3'd4: m_rot = 1;
        3'd1: e_eoi = 1;
        3'd5: begin e_eoi = 1; e_erot = 1; end
        3'd3: begin e_spec = 1; e_line = d[2:0]; end
        3'd7: begin e_spec = 1; e_erot = 1; e_line = d[2:0]; end
        3'd6: begin e_pset = 1; e_pbase = d[2:0] + 3'd1; end
        default: ;
      endcase
    end else begin
      case (m_state)
        0: m_imr = d;
        1: begin
          m_base = d & 8'hF8;
          m_state = m_single ? (m_need4 ? 3 : 0) : 2;
        end
        2: m_state = m_need4 ? 3 : 0;
        default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_state = 0; end
      endcase
    end
  endtask

  task automatic cmp_all();
    chk("R6", "imr", imr_o, m_imr);
    chk("R3", "base", base_o, m_base);
    chk("R1", "single", {7'b0, single_o}, {7'b0, m_single});
    chk("R4", "busy", {7'b0, init_busy_o}, {7'b0, m_state != 0});
    chk("R5", "sfnm/aeoi", {6'b0, sfnm_o, aeoi_o}, {6'b0, m_sfnm, m_aeoi});
    chk("R9", "rot_aeoi", {7'b0, rot_aeoi_o}, {7'b0, m_rot});
    chk("R7", "smask", {7'b0, smask_o}, {7'b0, m_smm});
    chk("R14", "trig", trig_mode_o, m_trig);
    chk("R1", "init_clear", {7'b0, init_clear_o}, {7'b0, e_clr});
    chk("R2", "level_err", {7'b0, level_err_o}, {7'b0, e_lerr});
    chk("R10", "eoi/rot", {6'b0, eoi_o, eoi_rot_o}, {6'b0, e_eoi, e_erot});
    chk("R11", "eoi_spec", {7'b0, eoi_spec_o}, {7'b0, e_spec});
    if (e_spec) chk("R11", "eoi_line", {5'b0, eoi_line_o}, {5'b0, e_line});
    chk("R12", "prio_set", {7'b0, prio_set_o}, {7'b0, e_pset});
    if (e_pset) chk("R12", "prio_base", {5'b0, prio_base_o}, {5'b0, e_pbase});
  endtask

  task automatic do_write(bit sel, bit a, logic [7:0] d);
    @(negedge clk);
    tm_sel = sel; addr = a; wdata = d; wr = 1;
    mdl_write(sel, a, d);
    @(negedge clk);
    wr = 0;
    cmp_all();
  endtask

  task automatic do_read(bit sel, bit a);
    string tag;
    @(negedge clk);
    tm_sel = sel; addr = a; rd = 1;
    clr_pulses();
    tag = "R13";
    if (sel) begin m_rdata = m_trig; tag = "R14"; end
    else if (a) m_rdata = m_imr;
    else if (m_poll) begin m_rdata = poll_byte(poll_hit_i, poll_line_i); m_poll = 0; tag = "R8"; end
    else m_rdata = m_rsel ? isr_i : irr_i;
    @(negedge clk);
    rd = 0;
    chk(tag, "rdata", rdata, m_rdata);
    cmp_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_state = 0; m_need4 = 0; m_single = 0; m_sfnm = 0; m_aeoi = 0;
    m_rot = 0; m_smm = 0; m_rsel = 0; m_poll = 0;
    m_imr = 0; m_base = 0; m_trig = 0; e_line = 0; e_pbase = 0;
    clr_pulses();
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_all();                       // reset state
    irr_i = 8'h3C; isr_i = 8'h41;
    // full cascade sequence with mode word (R1 R3 R4 R5)
    do_write(0, 0, 8'h11);
    do_write(0, 1, 8'h27);
    do_write(0, 1, 8'hFF);           // R4 cascade word, mask untouched
    do_write(0, 1, 8'h12);           // R5
    do_write(0, 1, 8'hA5);           // R6
    do_read(0, 1);
    do_read(0, 0);                   // IRR
    // single, no mode word, level flag (R2 R3)
    do_write(0, 0, 8'h1A);
    do_write(0, 1, 8'h4F);
    do_write(0, 1, 8'h5A);           // R6 mask load after short sequence
    // single with mode word
    do_write(0, 0, 8'h13);
    do_write(0, 1, 8'h88);
    do_write(0, 1, 8'h02);
    // read/mode commands (R7 R8)
    do_write(0, 0, 8'h0B);
    do_read(0, 0);                   // ISR
    do_write(0, 0, 8'h08);           // no enable: no change
    do_read(0, 0);
    do_write(0, 0, 8'h68);
    do_write(0, 0, 8'h28);           // enable clear: smask kept
    poll_hit_i = 1; poll_line_i = 3'd6;
    do_write(0, 0, 8'h0C);
    do_read(0, 1);                   // address 1 does not consume poll
    do_read(0, 0);                   // R8 poll byte 86
    do_read(0, 0);                   // back to ISR
    poll_hit_i = 0;
    do_write(0, 0, 8'h0C);
    do_read(0, 0);                   // R8 no request -> 00
    // action commands (R9-R12)
    do_write(0, 0, 8'h80);
    do_write(0, 0, 8'h00);
    do_write(0, 0, 8'h20);
    do_write(0, 0, 8'hA0);
    do_write(0, 0, 8'h63);
    do_write(0, 0, 8'hE5);
    do_write(0, 0, 8'hC7);           // wrap to 0
    do_write(0, 0, 8'hC2);
    do_write(0, 0, 8'h40);           // no-op
    // trigger register (R14)
    do_write(1, 0, 8'hFF);
    do_read(1, 1);
    do_write(1, 1, 8'h07);
    do_read(1, 0);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      d = 8'($urandom);
      irr_i = 8'($urandom); isr_i = 8'($urandom);
      poll_hit_i = 1'($urandom); poll_line_i = 3'($urandom);
      if (op < 3) begin
        if ($urandom_range(0, 7) != 0) d[4] = 1'b0;
        do_write(0, 0, d);
      end else if (op < 6) do_write(0, 1, d);
      else if (op == 6) do_write(1, 1'($urandom), d);
      else do_read(1'($urandom_range(0, 3) == 0), 1'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule